// File: doc/BRIEF.md
# Boot Memory Preparation Sequencer

This block prepares a unified, word-addressed memory before a small 32-bit processor leaves reset. It walks the whole memory writing zero to every word. It then moves the initialised-data image one 32-bit word at a time. The source is the image's storage location in the read-only region and the destination is its execution location in the writable region. The processor stays in reset for the whole time and is released only once both passes have finished.

Three byte-address inputs describe the copy: where the image is stored, where it must live at run time, and the first byte past its run-time end. The addresses are 4-byte aligned. A byte address becomes a word index when its two low bits are dropped. The engine drives a single memory port with a write strobe, a read strobe, a word index and write data. Read data returns one cycle after the read strobe.

The engine writes the clear pass to every index, including the read-only region. The memory is expected to discard writes there, so the stored image survives. With the default map, the read-only region starts at byte 0x100, which is also the processor's reset vector, and the writable region starts at byte 0x20000.

Top module: `bootprep_engine`

## Requirements
- R1: While `rst` is high, and on the first falling clock edge after it is raised mid-sequence, `prep_done` is 0, `core_hold` is 1, and neither `mem_we` nor `mem_re` is asserted.
- R2: After reset is released, the engine spends one cycle idle. It then writes zero to word indices 0, 1, … MEM_WORDS-1 in ascending order, one write per cycle.
- R3: No read and no copy write happens before the last clear write, and `core_hold` stays 1 for as long as `prep_done` is 0.
- R4: The copy moves (end − run)/4 words. Source indices run upward from load>>2 and destination indices run upward from run>>2.
- R5: Each copied word takes a read cycle (`mem_re`=1 at the source index) followed by a write cycle (`mem_we`=1 at the destination index). The written data equals the `mem_rdata` value returned for that read.
- R6: When end ≤ run, no read or copy write occurs, and `prep_done` rises the cycle after the last clear write.
- R7: When the load address equals the run address, the sequence still completes. Each word is read and written back to the same index.
- R8: `prep_done` stays 1 until the next reset. `core_hold` is still 1 in the first cycle `prep_done` is 1, and is 0 from the next cycle on. No memory access occurs after completion.
- R9: The three address inputs are sampled only in the idle cycle after reset. Changing them later has no effect on the sequence.
- R10: `mem_we` and `mem_re` are never asserted together.
- R11: `prep_done` first reads 1 exactly 1 + MEM_WORDS + 2·N clock edges after reset is released, where N is the word count of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load_addr | input | 32 | Byte address of the data image in the read-only region |
| cfg_run_addr | input | 32 | Byte address where the data image must live at run time |
| cfg_end_addr | input | 32 | Byte address one past the run-time image |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_idx | output | $clog2(MEM_WORDS) | Word index of the current access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_re` |
| prep_done | output | 1 | Preparation complete, sticky until reset |
| core_hold | output | 1 | Processor reset request, active high |

## Verification
Several properties are checked on every cycle by the assertions:
- the read and write strobes never coincide;
- the processor stays held while the sequence is unfinished, and is released exactly one cycle after completion;
- completion is sticky;
- the clear index steps by one;
- the source and destination indices step together after each copy write;
- every copy write directly follows a read.

Other behaviours only the bench scenarios can show: the final memory image, the exact cycle total for a given span, the skip taken for an empty or inverted span, and the same-address rewrite. The bench also covers that configuration changes made during the run are ignored, and that a mid-sequence reset returns the block to its initial state.

// File: rtl/bootprep_pkg.sv
package bootprep_pkg;

    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int BYTE_SHIFT = 2;
    localparam int CNT_W      = ADDR_W - BYTE_SHIFT;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CLEAR   = 3'd1,
        ST_COPY_RD = 3'd2,
        ST_COPY_WR = 3'd3,
        ST_DONE    = 3'd4
    } prep_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] load_addr;
        logic [ADDR_W-1:0] run_addr;
        logic [ADDR_W-1:0] end_addr;
    } prep_cfg_t;

    typedef struct packed {
        logic              we;
        logic              re;
        logic [DATA_W-1:0] data;
    } port_op_t;

    // Number of 32-bit words spanned by the run-time image; empty when inverted.
    function automatic logic [CNT_W-1:0] copy_words(input prep_cfg_t c);
        logic [ADDR_W-1:0] span;
        if (c.end_addr > c.run_addr)
            span = c.end_addr - c.run_addr;
        else
            span = '0;
        return CNT_W'(span >> BYTE_SHIFT);
    endfunction

    // Byte address to word index: drop the two low bits.
    function automatic logic [ADDR_W-1:0] word_of(input logic [ADDR_W-1:0] byte_addr);
        return byte_addr >> BYTE_SHIFT;
    endfunction

endpackage

// File: rtl/bootprep_fsm.sv
module bootprep_fsm
    import bootprep_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr_last_i,
    input  logic        copy_last_i,
    input  logic        len_zero_i,
    output prep_state_e state_o,
    output logic        done_o,
    output logic        core_hold_o
);

    prep_state_e state_q;
    prep_state_e state_d;
    logic        hold_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = ST_CLEAR;
            ST_CLEAR: begin
                if (clr_last_i)
                    state_d = len_zero_i ? ST_DONE : ST_COPY_RD;
            end
            ST_COPY_RD: state_d = ST_COPY_WR;
            ST_COPY_WR: state_d = copy_last_i ? ST_DONE : ST_COPY_RD;
            ST_DONE:    state_d = ST_DONE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            hold_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            hold_q  <= (state_q != ST_DONE);
        end
    end

    assign state_o     = state_q;
    assign done_o      = (state_q == ST_DONE);
    assign core_hold_o = hold_q;

    // R5: a copy write is always preceded by its read cycle
    p_wr_after_rd_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COPY_WR) |-> ($past(state_q) == ST_COPY_RD));

    // R8: completion is sticky
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE) |=> (state_q == ST_DONE));

    // R3: copying begins only from the final clear cycle
    p_copy_after_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COPY_RD && $past(state_q) != ST_COPY_WR) |->
            ($past(state_q) == ST_CLEAR));

endmodule

// File: rtl/bootprep_addr_gen.sv
module bootprep_addr_gen
    import bootprep_pkg::*;
#(
    parameter int MEM_WORDS = 65536,
    parameter int IDX_W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  prep_state_e      state_i,
    input  prep_cfg_t        cfg_i,
    output logic [IDX_W-1:0] clr_idx_o,
    output logic [IDX_W-1:0] src_idx_o,
    output logic [IDX_W-1:0] dst_idx_o,
    output logic             clr_last_o,
    output logic             copy_last_o,
    output logic             len_zero_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MEM_WORDS - 1);
    localparam logic [CNT_W-1:0] ONE_WORD = CNT_W'(1);

    logic [IDX_W-1:0] clr_q;
    logic [IDX_W-1:0] src_q;
    logic [IDX_W-1:0] dst_q;
    logic [CNT_W-1:0] remain_q;
    logic             len_zero_q;
    logic [CNT_W-1:0] span_words;

    assign span_words = copy_words(cfg_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_q      <= '0;
            src_q      <= '0;
            dst_q      <= '0;
            remain_q   <= '0;
            len_zero_q <= 1'b1;
        end else begin
            unique case (state_i)
                ST_IDLE: begin
                    clr_q      <= '0;
                    src_q      <= IDX_W'(word_of(cfg_i.load_addr));
                    dst_q      <= IDX_W'(word_of(cfg_i.run_addr));
                    remain_q   <= span_words;
                    len_zero_q <= (span_words == '0);
                end
                ST_CLEAR: clr_q <= clr_q + 1'b1;
                ST_COPY_WR: begin
                    src_q    <= src_q + 1'b1;
                    dst_q    <= dst_q + 1'b1;
                    remain_q <= remain_q - 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign clr_idx_o   = clr_q;
    assign src_idx_o   = src_q;
    assign dst_idx_o   = dst_q;
    assign clr_last_o  = (clr_q == LAST_IDX);
    assign copy_last_o = (remain_q == ONE_WORD);
    assign len_zero_o  = len_zero_q;

    // R2: the clear walk advances by exactly one word per cycle
    p_clear_step_r2: assert property (@(posedge clk) disable iff (rst)
        (state_i == ST_CLEAR && $past(state_i) == ST_CLEAR) |->
            (clr_q == $past(clr_q) + 1'b1));

    // R4: both pointers advance together after every copy write
    p_copy_step_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(state_i) == ST_COPY_WR) |->
            (src_q == $past(src_q) + 1'b1 && dst_q == $past(dst_q) + 1'b1));

    // R9: pointers do not move while a word is in flight
    p_ptr_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (state_i == ST_COPY_WR) |-> ($stable(src_q) && $stable(dst_q)));

endmodule

// File: rtl/bootprep_port_mux.sv
module bootprep_port_mux
    import bootprep_pkg::*;
#(
    parameter int IDX_W = 16
) (
    input  prep_state_e       state_i,
    input  logic [IDX_W-1:0]  clr_idx_i,
    input  logic [IDX_W-1:0]  src_idx_i,
    input  logic [IDX_W-1:0]  dst_idx_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              we_o,
    output logic              re_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [DATA_W-1:0] wdata_o
);

    port_op_t op;

    always_comb begin
        op    = '{we: 1'b0, re: 1'b0, data: '0};
        idx_o = '0;
        unique case (state_i)
            ST_CLEAR: begin
                op.we = 1'b1;
                idx_o = clr_idx_i;
            end
            ST_COPY_RD: begin
                op.re = 1'b1;
                idx_o = src_idx_i;
            end
            ST_COPY_WR: begin
                op.we   = 1'b1;
                op.data = rd_data_i;
                idx_o   = dst_idx_i;
            end
            default: ;
        endcase
    end

    assign we_o    = op.we;
    assign re_o    = op.re;
    assign wdata_o = op.data;

endmodule

// File: rtl/bootprep_engine.sv
module bootprep_engine
    import bootprep_pkg::*;
#(
    parameter int MEM_WORDS = 65536,
    localparam int IDX_W    = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cfg_load_addr,
    input  logic [ADDR_W-1:0] cfg_run_addr,
    input  logic [ADDR_W-1:0] cfg_end_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [IDX_W-1:0]  mem_idx,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              prep_done,
    output logic              core_hold
);

    prep_state_e      state;
    prep_cfg_t        cfg;
    logic [IDX_W-1:0] clr_idx;
    logic [IDX_W-1:0] src_idx;
    logic [IDX_W-1:0] dst_idx;
    logic             clr_last;
    logic             copy_last;
    logic             len_zero;

    assign cfg = '{load_addr: cfg_load_addr,
                   run_addr:  cfg_run_addr,
                   end_addr:  cfg_end_addr};

    bootprep_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .clr_last_i  (clr_last),
        .copy_last_i (copy_last),
        .len_zero_i  (len_zero),
        .state_o     (state),
        .done_o      (prep_done),
        .core_hold_o (core_hold)
    );

    bootprep_addr_gen #(
        .MEM_WORDS (MEM_WORDS),
        .IDX_W     (IDX_W)
    ) u_addr (
        .clk         (clk),
        .rst         (rst),
        .state_i     (state),
        .cfg_i       (cfg),
        .clr_idx_o   (clr_idx),
        .src_idx_o   (src_idx),
        .dst_idx_o   (dst_idx),
        .clr_last_o  (clr_last),
        .copy_last_o (copy_last),
        .len_zero_o  (len_zero)
    );

    bootprep_port_mux #(
        .IDX_W (IDX_W)
    ) u_mux (
        .state_i   (state),
        .clr_idx_i (clr_idx),
        .src_idx_i (src_idx),
        .dst_idx_i (dst_idx),
        .rd_data_i (mem_rdata),
        .we_o      (mem_we),
        .re_o      (mem_re),
        .idx_o     (mem_idx),
        .wdata_o   (mem_wdata)
    );

    // R10: single port, never read and write at once
    p_port_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    // R3: processor held while preparation is unfinished
    p_hold_until_done_r3: assert property (@(posedge clk) disable iff (rst)
        !prep_done |-> core_hold);

    // R8: release happens exactly one cycle after completion
    p_release_timing_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(prep_done) |-> core_hold);
    p_release_next_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(prep_done) |=> !core_hold);

    // R8: no memory traffic after completion
    p_quiet_after_done_r8: assert property (@(posedge clk) disable iff (rst)
        prep_done |-> (!mem_we && !mem_re));

endmodule

// File: tb/bootprep_engine_tb_top.sv
module bootprep_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 256;
    localparam int ROM_LIM    = 128;   // word indices below this ignore writes

    // stimulus table: load, run, end byte addresses
    localparam logic [31:0] VEC [4][3] = '{
        '{32'h040, 32'h280, 32'h2A0},
        '{32'h100, 32'h200, 32'h204},
        '{32'h000, 32'h300, 32'h400},
        '{32'h1FC, 32'h3FC, 32'h400}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_load_addr = '0;
    logic [31:0] cfg_run_addr  = '0;
    logic [31:0] cfg_end_addr  = '0;
    logic        mem_we, mem_re, prep_done, core_hold;
    logic [7:0]  mem_idx;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;

    logic [31:0] mem [W];

    int n_chk = 0, n_fail = 0;
    int ref_src = 0, ref_dst = 0;
    int clr_cnt, rd_cnt, cwr_cnt, clr_err, ord_err, cpy_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    bootprep_engine #(.MEM_WORDS(W)) dut_i (
        .clk (clk), .rst (rst),
        .cfg_load_addr (cfg_load_addr), .cfg_run_addr (cfg_run_addr),
        .cfg_end_addr (cfg_end_addr),
        .mem_we (mem_we), .mem_re (mem_re), .mem_idx (mem_idx),
        .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
        .prep_done (prep_done), .core_hold (core_hold)
    );

    function automatic logic [31:0] pat(input int i);
        return (i * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    function automatic logic [31:0] src_val(input int i);
        return (i < ROM_LIM) ? pat(i) : 32'h0;
    endfunction

    // memory model: read-only region discards writes, reads have one cycle latency
    always @(posedge clk) begin
        if (mem_we && int'(mem_idx) >= ROM_LIM) mem[mem_idx] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_idx];
    end

    // access-order monitor
    always @(negedge clk) begin
        if (rst) begin
            clr_cnt = 0; rd_cnt = 0; cwr_cnt = 0;
            clr_err = 0; ord_err = 0; cpy_err = 0;
        end else if (mem_we && mem_re) begin
            ord_err++;
        end else if (mem_we && clr_cnt < W) begin
            if (int'(mem_idx) != clr_cnt || mem_wdata != 0) clr_err++;
            clr_cnt++;
        end else if (mem_re) begin
            if (clr_cnt != W || rd_cnt != cwr_cnt) ord_err++;
            if (int'(mem_idx) != ref_src + rd_cnt) cpy_err++;
            rd_cnt++;
        end else if (mem_we) begin
            if (rd_cnt != cwr_cnt + 1) ord_err++;
            if (int'(mem_idx) != ref_dst + cwr_cnt ||
                mem_wdata != src_val(ref_src + cwr_cnt)) cpy_err++;
            cwr_cnt++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic fill_mem();
        for (int i = 0; i < W; i++)
            mem[i] = (i < ROM_LIM) ? pat(i) : (32'hDEAD0000 | i);
    endtask

    task automatic check_reset_state(input string tag);
        chk(!prep_done && core_hold && !mem_we && !mem_re, tag,
            {prep_done, core_hold, mem_we, mem_re}, 4'b0100);
    endtask

    task automatic run_case(input logic [31:0] ld, input logic [31:0] rn,
                            input logic [31:0] en, input bit chg_cfg);
        int n, k, bad, rs, bad_at;
        ref_src = int'(ld >> 2);
        ref_dst = int'(rn >> 2);
        n  = (en > rn) ? int'((en - rn) >> 2) : 0;
        cfg_load_addr = ld; cfg_run_addr = rn; cfg_end_addr = en;
        fill_mem();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_reset_state("R1 reset outputs");
        rst = 1'b0;
        k = 0;
        while (!prep_done && k < W + 4000) begin
            @(negedge clk);
            k++;
            if (chg_cfg && k == 10) begin
                cfg_load_addr = 32'h000; cfg_run_addr = 32'h300; cfg_end_addr = 32'h400;
            end
        end
        chk(k == 1 + W + 2 * n, "R11 cycles to done", k, 1 + W + 2 * n);
        chk(clr_cnt == W && clr_err == 0, "R2 clear walk", clr_err, 0);
        chk(ord_err == 0, "R3 R10 access order", ord_err, 0);
        chk(rd_cnt == n && cwr_cnt == n, "R4 word count", cwr_cnt, n);
        chk(cpy_err == 0, "R5 copy index and data", cpy_err, 0);
        chk(core_hold == 1'b1, "R8 hold at done entry", core_hold, 1);
        @(negedge clk);
        chk(core_hold == 1'b0, "R8 release after done", core_hold, 0);
        bad = 0; bad_at = -1;
        for (int i = 0; i < W; i++) begin
            logic [31:0] e;
            rs = i - ref_dst;
            if (i < ROM_LIM)             e = pat(i);
            else if (rs >= 0 && rs < n)  e = src_val(ref_src + rs);
            else                         e = 32'h0;
            if (mem[i] !== e) begin bad++; if (bad_at < 0) bad_at = i; end
        end
        chk(bad == 0, "R4 R2 final memory image", bad, 0);
        for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            chk(prep_done && !core_hold && !mem_we && !mem_re, "R8 sticky done",
                {prep_done, core_hold, mem_we, mem_re}, 4'b1000);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        check_reset_state("R1 initial reset");

        // table walk: R2 R4 R5 R11 over several spans
        for (int v = 0; v < 4; v++)
            run_case(VEC[v][0], VEC[v][1], VEC[v][2], 1'b0);

        // R6: empty and inverted spans skip the copy
        run_case(32'h040, 32'h280, 32'h280, 1'b0);
        run_case(32'h040, 32'h280, 32'h200, 1'b0);

        // R7: same load and run address, in each region
        run_case(32'h040, 32'h040, 32'h060, 1'b0);
        run_case(32'h280, 32'h280, 32'h290, 1'b0);

        // R9: configuration changed mid-run is ignored
        run_case(32'h040, 32'h280, 32'h2A0, 1'b1);

        // R1: reset raised in the middle of the clear pass
        cfg_load_addr = 32'h040; cfg_run_addr = 32'h280; cfg_end_addr = 32'h2A0;
        rst = 1'b1; repeat (2) @(negedge clk);
        rst = 1'b0; repeat (50) @(negedge clk);
        rst = 1'b1; @(negedge clk);
        check_reset_state("R1 mid-run reset");
        run_case(32'h040, 32'h280, 32'h2A0, 1'b0);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule